// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pin Overrides

This block is one eight-bit general-purpose I/O port of a small microcontroller. Software reaches three registers over a simple register bus: a direction register, an output latch and a pin-level view. Each pin leaves the block as a separate output-data bit and output-enable bit, so the pad ring builds the tri-state driver. A direction bit of 1 makes its pin an input, and a direction bit of 0 drives the latch bit onto the pin. The pin levels pass through a two-flop synchronizer before any logic inside the block uses them.

Other functions can take the pins over in a fixed priority. The external multiplexed address/data bus has the highest priority. While it is enabled, it owns the whole byte, which carries address/data bits 15 to 8. Next, a capture/compare/PWM peripheral can take pin 7 in place of the latch bit. Ordinary latch and direction control has the lowest priority. Separately, a slave-port mode taps the synchronized levels of pins 0, 1 and 2 as the read strobe, the write strobe and the chip select of a parallel slave port. This mode never changes how those pins are driven.

Top module: `gpio_port_ovr`

## Requirements
- R1: After reset the direction register reads 0xFF and the latch reads 0x00. With the external bus disabled, every pin_oe bit is 0.
- R2: A write with bus_addr=2 loads bus_wdata into the direction register at the next clock edge. A read with bus_addr=2 returns the direction register.
- R3: With external-bus mode off, pin_oe[i] is the inverse of direction bit i. pin_out carries the latch on every pin except when R8 applies to pin 7.
- R4: A read with bus_addr=1 returns the latch contents, whatever the pin levels are. A write with bus_addr=1 loads the latch.
- R5: A write with bus_addr=0 loads the latch. A read with bus_addr=0 returns the synchronized pin levels.
- R6: A change on pin_in shows on a bus_addr=0 read after the second rising clock edge. It does not show after the first.
- R7: While xbus_disable=0, pin_out equals xbus_ad_out and every pin_oe bit equals xbus_ad_oe. The direction register has no effect in this mode.
- R8: While xbus_disable=1 and alt_map_n=0, pin_out[7] equals periph_out and pin_oe[7] still follows direction bit 7. While xbus_disable=0, the external bus wins on pin 7.
- R9: While slave_mode=1, slv_rd_n, slv_wr_n and slv_cs_n equal the synchronized levels of pins 0, 1 and 2. While slave_mode=0, all three read 1. The slave mode never changes pin_oe.
- R10: Address 3 reads 0x00, and a write to address 3 changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 pins/latch, 1 latch, 2 direction) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pin_out | output | 8 | Pad output data |
| pin_oe | output | 8 | Pad output enable, 1 drives |
| xbus_disable | input | 1 | 1 = external bus off, normal I/O |
| xbus_ad_out | input | 8 | High byte of address/data from the bus controller |
| xbus_ad_oe | input | 1 | Bus controller drives the byte |
| xbus_ad_in | output | 8 | Synchronized pin levels for the bus controller |
| alt_map_n | input | 1 | 0 = peripheral signal on pin 7 |
| periph_out | input | 1 | Capture/compare/PWM output |
| slave_mode | input | 1 | Parallel slave port active |
| slv_rd_n | output | 1 | Slave read strobe (pin 0) |
| slv_wr_n | output | 1 | Slave write strobe (pin 1) |
| slv_cs_n | output | 1 | Slave chip select (pin 2) |

## Verification
The hardest case is two overrides active at once, such as external-bus mode together with the pin-7 peripheral mapping, while the direction register holds a mix of input and output bits. The bench first loads a mixed direction value and a latch pattern that differs from both the bus byte and the peripheral bit. It then turns the modes on and off in stages, so that each output bit can only match its expected value if the correct source won. Pin levels are changed just after an edge and read one and two edges later, which pins down the synchronizer depth.

// File: rtl/gpio_pkg.sv
// Package gpio_pkg
// Register map and fixed slave-port pin positions shared by the port logic.
// Assumes a 2-bit register address.
package gpio_pkg;
    typedef enum logic [1:0] {
        REG_PINS = 2'd0,
        REG_LAT  = 2'd1,
        REG_DIR  = 2'd2,
        REG_NONE = 2'd3
    } reg_addr_e;

    localparam int SLV_RD_BIT = 0;
    localparam int SLV_WR_BIT = 1;
    localparam int SLV_CS_BIT = 2;
endpackage

// File: rtl/gpio_pin_sync.sv
// Module gpio_pin_sync
// Multi-stage synchronizer for asynchronous pad levels.
// Assumes STAGES >= 2. The stages clear to 0 on reset.
module gpio_pin_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // First stage captures the raw pad levels.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_in;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage copies the stage before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
// Module gpio_port_regs
// Direction and latch registers with the combinational read mux.
// Assumes single-cycle write strobes. Reads carry no side effects.
module gpio_port_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] pins_sync,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] lat_q,
    output logic [WIDTH-1:0] rdata
);
    logic lat_hit;
    logic dir_hit;

    assign lat_hit = wr_en && (addr == REG_PINS || addr == REG_LAT);
    assign dir_hit = wr_en && (addr == REG_DIR);

    // Direction register; all pins come up as inputs.
    always_ff @(posedge clk) begin
        if (!rst_n)       dir_q <= '1;
        else if (dir_hit) dir_q <= wdata;
    end

    // Output latch; the pin address and the latch address both write it.
    always_ff @(posedge clk) begin
        if (!rst_n)       lat_q <= '0;
        else if (lat_hit) lat_q <= wdata;
    end

    // Read mux: the pin address shows levels, the latch address shows the latch.
    always_comb begin
        unique case (addr)
            REG_PINS: rdata = pins_sync;
            REG_LAT:  rdata = lat_q;
            REG_DIR:  rdata = dir_q;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pin_mux.sv
// Module gpio_pin_mux
// Per-pin priority: external bus, then the alternate peripheral on ALT_PIN,
// then the latch and direction. It also taps the slave-port strobes.
// Assumes the slave-port pins are set as inputs by software.
module gpio_pin_mux
    import gpio_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int ALT_PIN = 7
) (
    input  logic             xbus_disable,
    input  logic [WIDTH-1:0] xbus_ad_out,
    input  logic             xbus_ad_oe,
    input  logic             alt_map_n,
    input  logic             periph_out,
    input  logic             slave_mode,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] lat_q,
    input  logic [WIDTH-1:0] pins_sync,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic             slv_rd_n,
    output logic             slv_wr_n,
    output logic             slv_cs_n
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            logic norm_d;
            if (i == ALT_PIN) begin : g_alt
                assign norm_d = alt_map_n ? lat_q[i] : periph_out;
            end else begin : g_plain
                assign norm_d = lat_q[i];
            end

            // Select the pin owner by priority.
            always_comb begin
                if (!xbus_disable) begin
                    pin_out[i] = xbus_ad_out[i];
                    pin_oe[i]  = xbus_ad_oe;
                end else begin
                    pin_out[i] = norm_d;
                    pin_oe[i]  = ~dir_q[i];
                end
            end
        end
    endgenerate

    // Slave-port strobes idle high when the mode is off.
    always_comb begin
        if (slave_mode) begin
            slv_rd_n = pins_sync[SLV_RD_BIT];
            slv_wr_n = pins_sync[SLV_WR_BIT];
            slv_cs_n = pins_sync[SLV_CS_BIT];
        end else begin
            slv_rd_n = 1'b1;
            slv_wr_n = 1'b1;
            slv_cs_n = 1'b1;
        end
    end
endmodule

// File: rtl/gpio_port_ovr.sv
// Module gpio_port_ovr
// Top of the GPIO port: synchronizer, register file and pin override mux.
// Assumes the pad ring builds the tri-state drivers from pin_out and pin_oe.
module gpio_port_ovr #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ALT_PIN     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    input  logic             xbus_disable,
    input  logic [WIDTH-1:0] xbus_ad_out,
    input  logic             xbus_ad_oe,
    output logic [WIDTH-1:0] xbus_ad_in,
    input  logic             alt_map_n,
    input  logic             periph_out,
    input  logic             slave_mode,
    output logic             slv_rd_n,
    output logic             slv_wr_n,
    output logic             slv_cs_n
);
    logic [WIDTH-1:0] pins_sync;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] lat_q;

    gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pins_sync)
    );

    gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .pins_sync (pins_sync),
        .dir_q     (dir_q),
        .lat_q     (lat_q),
        .rdata     (bus_rdata)
    );

    gpio_pin_mux #(.WIDTH(WIDTH), .ALT_PIN(ALT_PIN)) u_mux (
        .xbus_disable (xbus_disable),
        .xbus_ad_out  (xbus_ad_out),
        .xbus_ad_oe   (xbus_ad_oe),
        .alt_map_n    (alt_map_n),
        .periph_out   (periph_out),
        .slave_mode   (slave_mode),
        .dir_q        (dir_q),
        .lat_q        (lat_q),
        .pins_sync    (pins_sync),
        .pin_out      (pin_out),
        .pin_oe       (pin_oe),
        .slv_rd_n     (slv_rd_n),
        .slv_wr_n     (slv_wr_n),
        .slv_cs_n     (slv_cs_n)
    );

    assign xbus_ad_in = pins_sync;
endmodule

// File: rtl/gpio_port_ovr_chk.sv
// Module gpio_port_ovr_chk
// Property checker for gpio_port_ovr, attached by bind.
// Assumes the default map: pins at 0, latch at 1, direction at 2.
module gpio_port_ovr_chk #(
    parameter int WIDTH   = 8,
    parameter int ALT_PIN = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] bus_rdata,
    input logic [WIDTH-1:0] pin_in,
    input logic [WIDTH-1:0] pin_out,
    input logic [WIDTH-1:0] pin_oe,
    input logic             xbus_disable,
    input logic [WIDTH-1:0] xbus_ad_out,
    input logic             xbus_ad_oe,
    input logic             alt_map_n,
    input logic             periph_out,
    input logic             slave_mode,
    input logic             slv_rd_n,
    input logic             slv_wr_n,
    input logic             slv_cs_n,
    input logic [WIDTH-1:0] dir_q,
    input logic [WIDTH-1:0] lat_q
);
    logic [1:0] since_rst;

    // Count edges since reset, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 2) since_rst <= since_rst + 2'd1;
    end

    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2) |=> (dir_q == $past(bus_wdata)));

    a_r4_lat_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1) |=> (lat_q == $past(bus_wdata)));

    a_r3_oe_dir: assert property (@(posedge clk) disable iff (!rst_n)
        xbus_disable |-> (pin_oe == ~dir_q));

    a_r6_sync_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2 && bus_addr == 2'd0) |-> (bus_rdata == $past(pin_in, 2)));

    a_r7_xbus_owns: assert property (@(posedge clk) disable iff (!rst_n)
        !xbus_disable |-> (pin_out == xbus_ad_out && pin_oe == {WIDTH{xbus_ad_oe}}));

    a_r8_alt_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (xbus_disable && !alt_map_n) |-> (pin_out[ALT_PIN] == periph_out));

    a_r9_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !slave_mode |-> (slv_rd_n && slv_wr_n && slv_cs_n));

    a_r10_unused_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd3) |-> (bus_rdata == '0));
endmodule

bind gpio_port_ovr gpio_port_ovr_chk #(.WIDTH(WIDTH), .ALT_PIN(ALT_PIN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .pin_in       (pin_in),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe),
    .xbus_disable (xbus_disable),
    .xbus_ad_out  (xbus_ad_out),
    .xbus_ad_oe   (xbus_ad_oe),
    .alt_map_n    (alt_map_n),
    .periph_out   (periph_out),
    .slave_mode   (slave_mode),
    .slv_rd_n     (slv_rd_n),
    .slv_wr_n     (slv_wr_n),
    .slv_cs_n     (slv_cs_n),
    .dir_q        (dir_q),
    .lat_q        (lat_q)
);

// File: tb/test_gpio_port_ovr.sv
// Directed bench for gpio_port_ovr: one task per scenario.
module test_gpio_port_ovr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic       xbus_disable = 1'b1;
    logic [7:0] xbus_ad_out = 8'h00;
    logic       xbus_ad_oe = 1'b0;
    logic [7:0] xbus_ad_in;
    logic       alt_map_n = 1'b1;
    logic       periph_out = 1'b0;
    logic       slave_mode = 1'b0;
    logic       slv_rd_n;
    logic       slv_wr_n;
    logic       slv_cs_n;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    gpio_port_ovr i_gpio_port_ovr (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .xbus_disable(xbus_disable),
        .xbus_ad_out(xbus_ad_out), .xbus_ad_oe(xbus_ad_oe), .xbus_ad_in(xbus_ad_in),
        .alt_map_n(alt_map_n), .periph_out(periph_out), .slave_mode(slave_mode),
        .slv_rd_n(slv_rd_n), .slv_wr_n(slv_wr_n), .slv_cs_n(slv_cs_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd_reg(2'd2, v); chk("R1 dir reset", v, 8'hFF);
        rd_reg(2'd1, v); chk("R1 latch reset", v, 8'h00);
        chk("R1 oe reset", pin_oe, 8'h00);
    endtask

    task automatic t_dir;
        logic [7:0] v;
        wr_reg(2'd2, 8'h03);
        rd_reg(2'd2, v); chk("R2 dir readback", v, 8'h03);
        chk("R3 oe from dir", pin_oe, 8'hFC);
    endtask

    task automatic t_latch;
        logic [7:0] v;
        wr_reg(2'd0, 8'hA5);
        rd_reg(2'd1, v); chk("R5 port write loads latch", v, 8'hA5);
        chk("R3 pin_out from latch", pin_out, 8'hA5);
        pin_in = 8'h3C;
        repeat (2) @(negedge clk);
        rd_reg(2'd0, v); chk("R5 port read shows pins", v, 8'h3C);
        rd_reg(2'd1, v); chk("R4 latch read ignores pins", v, 8'hA5);
        wr_reg(2'd1, 8'h5A);
        rd_reg(2'd1, v); chk("R4 latch write", v, 8'h5A);
    endtask

    task automatic t_sync;
        logic [7:0] v;
        @(negedge clk);
        pin_in = 8'hC3;
        @(negedge clk);
        rd_reg(2'd0, v); chk("R6 not after one edge", v, 8'h3C);
        @(negedge clk);
        rd_reg(2'd0, v); chk("R6 visible after two edges", v, 8'hC3);
    endtask

    task automatic t_xbus;
        @(negedge clk);
        xbus_disable = 1'b0; xbus_ad_out = 8'h16; xbus_ad_oe = 1'b1; alt_map_n = 1'b0;
        periph_out = 1'b1;
        #1;
        chk("R7 bus drives data", pin_out, 8'h16);
        chk("R7 bus oe all", pin_oe, 8'hFF);
        chk("R8 bus beats peripheral", {7'd0, pin_out[7]}, 8'h00);
        xbus_ad_oe = 1'b0;
        #1;
        chk("R7 dir ignored", pin_oe, 8'h00);
        xbus_disable = 1'b1; alt_map_n = 1'b1; periph_out = 1'b0;
    endtask

    task automatic t_alt;
        @(negedge clk);
        alt_map_n = 1'b0; periph_out = 1'b1;
        #1;
        chk("R8 peripheral on pin 7", pin_out, 8'hDA);
        chk("R8 oe still from dir", pin_oe, 8'hFC);
        periph_out = 1'b0;
        #1;
        chk("R8 peripheral low", pin_out, 8'h5A);
        alt_map_n = 1'b1; periph_out = 1'b1;
        #1;
        chk("R8 latch back on pin 7", pin_out, 8'h5A);
        periph_out = 1'b0;
    endtask

    task automatic t_slave;
        @(negedge clk);
        pin_in = 8'h05;
        repeat (2) @(negedge clk);
        #1;
        chk("R9 idle strobes", {5'd0, slv_cs_n, slv_wr_n, slv_rd_n}, 8'h07);
        slave_mode = 1'b1;
        #1;
        chk("R9 strobes from pins", {5'd0, slv_cs_n, slv_wr_n, slv_rd_n}, 8'h05);
        wr_reg(2'd2, 8'h00);
        #1;
        chk("R9 oe not forced", pin_oe, 8'hFF);
        slave_mode = 1'b0;
    endtask

    task automatic t_unused;
        logic [7:0] v;
        wr_reg(2'd3, 8'hEE);
        rd_reg(2'd3, v); chk("R10 unused reads zero", v, 8'h00);
        rd_reg(2'd2, v); chk("R10 dir untouched", v, 8'h00);
        rd_reg(2'd1, v); chk("R10 latch untouched", v, 8'h5A);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dir();
        t_latch();
        t_sync();
        t_xbus();
        t_alt();
        t_slave();
        t_unused();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule